// File: doc/BRIEF.md
# Multi-Channel Compare-Match Event Timer

This block is a register-mapped event timer. A 64-bit main counter advances by one on every clock while the global run bit is set. Several comparator channels watch that counter. Each channel can raise one interrupt when the counter reaches a chosen value, or raise one every fixed number of ticks. Software reaches every register through one 64-bit port, which accepts a single-cycle write strobe and returns read data combinationally from the address.

Each channel runs a small state machine with three states. CH_OFF means the interrupt enable is clear. CH_ARMED means the channel waits for a match. CH_SPENT means a one-shot channel has already fired. The transitions are:
- enable-set: CH_OFF to CH_ARMED, when the interrupt enable is written to 1.
- disable: CH_ARMED or CH_SPENT to CH_OFF, when the enable is written to 0.
- one-shot-fire: CH_ARMED to CH_SPENT, on a match while periodic mode is off.
- periodic-fire: CH_ARMED stays in CH_ARMED, and the comparator advances by the stored period.
- rearm: CH_SPENT to CH_ARMED, on any write to the channel's comparator or configuration.

A match means that the run bit is set, the state is CH_ARMED and the counter equals the comparator. Each interrupt line is either a one-cycle pulse (edge mode) or a latched status bit that software clears (level mode). Each channel's routed IRQ number is also driven out. The channel count must be at least 2. The tick period must be nonzero and no larger than 100,000,000 fs.

Top module: `evt_timer_top`

## Requirements
- R1: After reset, the counter, the run bit, the status register, every interrupt line and every route output read zero.
- R2: The capability word at 0x000 returns the tick period in femtoseconds in bits [63:32], a 1 in bit 13 (64-bit counter), and the channel count minus one in bits [12:8]. All other bits are zero.
- R3: Bit 0 of 0x010 is the run bit. While it is set, the counter at 0x0F0 rises by exactly one per clock. While it is clear, the counter holds.
- R4: A write to 0x0F0 loads the counter only while the run bit is clear. While the run bit is set, the write is ignored and counting continues.
- R5: Channel configuration bit 2 enables the interrupt. With bit 3 (periodic) clear, the channel fires once, in the cycle after the counter equals its comparator, and does not fire again until its comparator or configuration is written.
- R6: If a periodic channel (bit 3 set) has bit 6 set, a comparator write loads both the match value and the period, and bit 6 then reads back 0. Each match advances the comparator by the period, so events come every period ticks.
- R7: Configuration bit 4 reads 1 only on channels that support periodic mode, and bit 3 cannot be set on other channels. Bit 5 always reads 1. Bits [63:32] read the bitmap of IRQ numbers that may be routed.
- R8: With configuration bit 1 clear (edge mode), a fire drives the channel's interrupt line for one cycle and does not set its status bit.
- R9: With configuration bit 1 set (level mode), a fire sets bit n of 0x020 for channel n, and the interrupt line follows that bit. Writing 1 to the bit clears it. Writing 0 has no effect.
- R10: Configuration bits [13:9] set the route, which appears on the channel's 5-bit route output. A write of a route number whose bitmap bit is clear leaves the previous route in place.
- R11: While interrupt enable is clear, a channel never fires, even when the counter passes its comparator.
- R12: Channel n occupies 0x100 + 0x20*n, with configuration at +0x00 and comparator at +0x08. The message-route slot at +0x10, unmapped offsets and channels beyond the count read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the 64-bit register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr (combinational) |
| irq_o | output | NUM_CH | Interrupt line per channel |
| irq_route_o | output | 5*NUM_CH | Routed IRQ number per channel, channel n in bits [5n+4:5n] |

## Verification
On every cycle, the embedded properties check the counter's step and hold rules, that a load is refused while running, the comparator reload after each periodic match, that a spent or disabled channel stays silent, that an unwritten route stays fixed, and that status bits are sticky until cleared or set only by level fires. Only the bench scenarios can show the exact cycle and count of events. It sweeps the period from 1 to 6 and checks the count and placement of every reload. It also covers the one-shot timing, the latched level line with its clear rules, and the register readback layout, none of which a local property captures.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int REG_W = 64;

    // global register offsets
    localparam int OFF_GCAP    = 'h000;
    localparam int OFF_GCFG    = 'h010;
    localparam int OFF_GSTS    = 'h020;
    localparam int OFF_CNT     = 'h0F0;
    localparam int OFF_CH_BASE = 'h100;

    // per-channel offsets inside a 0x20 slot
    localparam int CH_OFF_CFG = 'h00;
    localparam int CH_OFF_CMP = 'h08;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ARMED = 2'd1,
        CH_SPENT = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic       level;
        logic       int_en;
        logic       periodic;
        logic       setcnt;
        logic [4:0] route;
    } ch_cfg_t;

endpackage

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (run_i)
            cnt_q <= cnt_q + W'(1);
        else if (load_i)
            cnt_q <= load_val_i;
    end

    assign cnt_o = cnt_q;

    assert_run_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> cnt_q == $past(cnt_q) + W'(1));

    assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(cnt_q));

    assert_halted_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && load_i) |=> cnt_q == $past(load_val_i));

endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
    import evt_timer_pkg::*;
#(
    parameter logic [31:0] ROUTE_MASK   = 32'h0000_0F04,
    parameter bit          CAN_PERIODIC = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [REG_W-1:0] cnt_i,
    input  logic             cfg_we_i,
    input  ch_cfg_t          cfg_i,
    input  logic             cmp_we_i,
    input  logic [REG_W-1:0] cmp_wdata_i,
    output logic [REG_W-1:0] cfg_rd_o,
    output logic [REG_W-1:0] cmp_rd_o,
    output logic             level_o,
    output logic [4:0]       route_o,
    output logic             hit_o
);

    ch_cfg_t          cfg_q;
    logic [REG_W-1:0] cmp_q, per_q;
    ch_state_e        st_q, st_d;
    logic             en_nx, hit;

    assign en_nx = cfg_we_i ? cfg_i.int_en : cfg_q.int_en;
    assign hit   = run_i && (st_q == CH_ARMED) && (cnt_i == cmp_q);

    // configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we_i) begin
            cfg_q.level    <= cfg_i.level;
            cfg_q.int_en   <= cfg_i.int_en;
            cfg_q.periodic <= CAN_PERIODIC && cfg_i.periodic;
            cfg_q.setcnt   <= CAN_PERIODIC && cfg_i.setcnt;
            if (ROUTE_MASK[cfg_i.route])
                cfg_q.route <= cfg_i.route;
        end else if (cmp_we_i) begin
            cfg_q.setcnt <= 1'b0;
        end
    end

    // comparator and reload period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            per_q <= '0;
        end else if (cmp_we_i) begin
            cmp_q <= cmp_wdata_i;
            if (cfg_q.periodic && cfg_q.setcnt)
                per_q <= cmp_wdata_i;
        end else if (hit && cfg_q.periodic) begin
            cmp_q <= cmp_q + per_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= CH_OFF;
        else
            st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_OFF: begin
                if (en_nx)
                    st_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (!en_nx)
                    st_d = CH_OFF;
                else if (cfg_we_i || cmp_we_i)
                    st_d = CH_ARMED;
                else if (hit && !cfg_q.periodic)
                    st_d = CH_SPENT;
            end
            CH_SPENT: begin
                if (!en_nx)
                    st_d = CH_OFF;
                else if (cfg_we_i || cmp_we_i)
                    st_d = CH_ARMED;
            end
            default: st_d = CH_OFF;
        endcase
    end

    // outputs
    assign cfg_rd_o = {ROUTE_MASK, 18'b0, cfg_q.route, 2'b0, cfg_q.setcnt, 1'b1,
                       CAN_PERIODIC, cfg_q.periodic, cfg_q.int_en, cfg_q.level, 1'b0};
    assign cmp_rd_o = cmp_q;
    assign level_o  = cfg_q.level;
    assign route_o  = cfg_q.route;
    assign hit_o    = hit;

    assert_spent_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_SPENT) |-> !hit_o);

    assert_reload_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && cfg_q.periodic && !cmp_we_i) |=> cmp_q == $past(cmp_q) + $past(per_q));

    assert_setcnt_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we_i && !cfg_we_i) |=> !cfg_q.setcnt);

    assert_route_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we_i |=> $stable(cfg_q.route));

    assert_disabled_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.int_en |-> (st_q == CH_OFF));

endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
    import evt_timer_pkg::*;
#(
    parameter int          NUM_CH        = 3,
    parameter int          ADDR_W        = 12,
    parameter logic [31:0] PERIOD_FS     = 32'd8000000,
    parameter logic [31:0] ROUTE_MASK    = 32'h0000_0F04,
    parameter logic [31:0] PERIODIC_MASK = 32'h0000_0003
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    output logic [NUM_CH-1:0]   irq_o,
    output logic [5*NUM_CH-1:0] irq_route_o
);

    localparam int CH_AW = ADDR_W - 5;

    logic                  run_q;
    logic [NUM_CH-1:0]     sts_q, pulse_q, hit, level;
    logic [REG_W-1:0]      cnt;
    logic [REG_W-1:0]      cfg_rd [NUM_CH];
    logic [REG_W-1:0]      cmp_rd [NUM_CH];
    logic [ADDR_W-1:0]     ch_rel;
    logic                  in_ch, cnt_load, sts_wr;
    logic [REG_W-1:0]      gcap;
    ch_cfg_t               cfg_in;

    assign ch_rel   = bus_addr - ADDR_W'(OFF_CH_BASE);
    assign in_ch    = bus_addr >= ADDR_W'(OFF_CH_BASE);
    assign cnt_load = bus_we && (bus_addr == ADDR_W'(OFF_CNT));
    assign sts_wr   = bus_we && (bus_addr == ADDR_W'(OFF_GSTS));
    assign gcap     = {PERIOD_FS, 18'b0, 1'b1, 5'(NUM_CH - 1), 8'b0};
    assign cfg_in   = '{level: bus_wdata[1], int_en: bus_wdata[2], periodic: bus_wdata[3],
                        setcnt: bus_wdata[6], route: bus_wdata[13:9]};

    // run bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (bus_we && (bus_addr == ADDR_W'(OFF_GCFG)))
            run_q <= bus_wdata[0];
    end

    evt_timer_counter #(.W(REG_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_q),
        .load_i     (cnt_load),
        .load_val_i (bus_wdata),
        .cnt_o      (cnt)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = in_ch && (ch_rel[ADDR_W-1:5] == CH_AW'(i));

        evt_timer_chan #(
            .ROUTE_MASK   (ROUTE_MASK),
            .CAN_PERIODIC (PERIODIC_MASK[i])
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .run_i       (run_q),
            .cnt_i       (cnt),
            .cfg_we_i    (bus_we && sel && (ch_rel[4:0] == 5'(CH_OFF_CFG))),
            .cfg_i       (cfg_in),
            .cmp_we_i    (bus_we && sel && (ch_rel[4:0] == 5'(CH_OFF_CMP))),
            .cmp_wdata_i (bus_wdata),
            .cfg_rd_o    (cfg_rd[i]),
            .cmp_rd_o    (cmp_rd[i]),
            .level_o     (level[i]),
            .route_o     (irq_route_o[5*i +: 5]),
            .hit_o       (hit[i])
        );

        // status latch and edge pulse
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sts_q[i]   <= 1'b0;
                pulse_q[i] <= 1'b0;
            end else begin
                pulse_q[i] <= hit[i] && !level[i];
                if (hit[i] && level[i])
                    sts_q[i] <= 1'b1;
                else if (sts_wr && bus_wdata[i])
                    sts_q[i] <= 1'b0;
            end
        end

        assign irq_o[i] = level[i] ? sts_q[i] : pulse_q[i];

        assert_edge_no_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && !level[i] && !sts_q[i]) |=> !sts_q[i]);

        assert_sts_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_q[i] && !(sts_wr && bus_wdata[i])) |=> sts_q[i]);
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_GCAP): bus_rdata = gcap;
            ADDR_W'(OFF_GCFG): bus_rdata = {63'b0, run_q};
            ADDR_W'(OFF_GSTS): bus_rdata = REG_W'(sts_q);
            ADDR_W'(OFF_CNT):  bus_rdata = cnt;
            default: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (in_ch && (ch_rel[ADDR_W-1:5] == CH_AW'(i))) begin
                        if (ch_rel[4:0] == 5'(CH_OFF_CFG))
                            bus_rdata = cfg_rd[i];
                        else if (ch_rel[4:0] == 5'(CH_OFF_CMP))
                            bus_rdata = cmp_rd[i];
                    end
                end
            end
        endcase
    end

endmodule

// File: tb/evt_timer_top_tb_top.sv
module evt_timer_top_tb_top;

    localparam int          NCH   = 3;
    localparam logic [31:0] PFS   = 32'd8000000;
    localparam logic [31:0] RMASK = 32'h0000_0F04;
    localparam logic [11:0] A_GCAP = 12'h000, A_GCFG = 12'h010, A_GSTS = 12'h020, A_CNT = 12'h0F0;
    localparam logic [63:0] CAPW  = {RMASK, 32'h0};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_we = 1'b0;
    logic [11:0]    bus_addr = '0;
    logic [63:0]    bus_wdata = '0;
    logic [63:0]    bus_rdata;
    logic [NCH-1:0] irq;
    logic [5*NCH-1:0] route;
    int             checks = 0;
    int             fails = 0;
    bit             done = 1'b0;

    always #4 clk = ~clk;

    evt_timer_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_o       (irq),
        .irq_route_o (route)
    );

    function automatic logic [11:0] ca(input int n, input int off);
        return 12'(12'h100 + 32 * n + off);
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // called just after a negedge; the write lands on the next posedge
    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // watch one interrupt line for a number of cycles, sampling the counter
    task automatic watch(input int ch, input int cycles, output int n,
                         output logic [63:0] first, output logic [63:0] last);
        n = 0; first = '0; last = '0;
        bus_addr = A_CNT;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            #1;
            if (irq[ch]) begin
                if (n == 0) first = bus_rdata;
                last = bus_rdata;
                n++;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] v, c0, first, last;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        rd(A_CNT, v);  chk("R1 counter", v, 64'd0);
        rd(A_GCFG, v); chk("R1 run bit", v, 64'd0);
        rd(A_GSTS, v); chk("R1 status", v, 64'd0);
        chk("R1 irq lines", 64'(irq), 64'd0);
        chk("R1 routes", 64'(route), 64'd0);

        // R2 capability word
        rd(A_GCAP, v);
        chk("R2 capability", v, {PFS, 18'b0, 1'b1, 5'(NCH - 1), 8'b0});

        // R7 / R12 channel layout
        rd(ca(0, 0), v);  chk("R7 ch0 caps", v, CAPW | 64'h30);
        rd(ca(2, 0), v);  chk("R7 ch2 caps", v, CAPW | 64'h20);
        rd(ca(0, 16), v); chk("R12 route slot", v, 64'd0);
        rd(12'h008, v);   chk("R12 unmapped", v, 64'd0);
        rd(ca(NCH, 0), v); chk("R12 beyond channels", v, 64'd0);

        // R4 halted load, R3 hold
        wr(A_CNT, 64'd100);
        rd(A_CNT, v); chk("R4 halted load", v, 64'd100);
        repeat (5) @(negedge clk);
        #1;
        rd(A_CNT, v); chk("R3 halted hold", v, 64'd100);

        // R3 counting rate
        wr(A_GCFG, 64'd1);
        rd(A_CNT, c0);
        repeat (7) @(negedge clk);
        #1;
        rd(A_CNT, v); chk("R3 run rate", v, c0 + 64'd7);

        // R4 blocked load while running
        rd(A_CNT, c0);
        wr(A_CNT, 64'd5);
        rd(A_CNT, v); chk("R4 write ignored", v, c0 + 64'd1);
        wr(A_GCFG, 64'd0);
        wr(A_CNT, 64'd0);

        // R7 periodic bit refused on a channel without support
        wr(ca(2, 0), 64'h8);
        rd(ca(2, 0), v); chk("R7 ch2 periodic refused", v, CAPW | 64'h20);

        // R5 / R8 one-shot edge on channel 0, route 2
        wr(ca(0, 0), (64'd2 << 9) | 64'h4);
        wr(ca(0, 8), 64'd20);
        chk("R10 route accepted", 64'(route[4:0]), 64'd2);
        wr(A_GCFG, 64'd1);
        watch(0, 60, n, first, last);
        chk("R5 one-shot count", 64'(n), 64'd1);
        chk("R5 one-shot cycle", first, 64'd21);
        rd(A_GSTS, v); chk("R8 edge leaves status", v, 64'd0);
        wr(A_GCFG, 64'd0);

        // R10 refused and accepted routes
        wr(ca(0, 0), (64'd3 << 9) | 64'h4);
        chk("R10 refused route", 64'(route[4:0]), 64'd2);
        wr(ca(0, 0), (64'd8 << 9) | 64'h4);
        chk("R10 new route", 64'(route[4:0]), 64'd8);
        rd(ca(0, 0), v); chk("R10 route readback", v, CAPW | (64'd8 << 9) | 64'h34);

        // R6 periodic with set-count on channel 1
        wr(A_CNT, 64'd0);
        wr(ca(1, 0), (64'd8 << 9) | 64'h4C);
        rd(ca(1, 0), v); chk("R6 strobe set", v, CAPW | (64'd8 << 9) | 64'h7C);
        wr(ca(1, 8), 64'd10);
        rd(ca(1, 0), v); chk("R6 strobe self-clear", v, CAPW | (64'd8 << 9) | 64'h3C);
        wr(A_GCFG, 64'd1);
        watch(1, 55, n, first, last);
        chk("R6 periodic count", 64'(n), 64'd5);
        chk("R6 periodic first", first, 64'd11);
        chk("R6 periodic last", last, 64'd51);
        wr(A_GCFG, 64'd0);
        rd(ca(1, 8), v); chk("R6 comparator advanced", v, 64'd60);

        // R6 sweep of short periods
        for (int p = 1; p <= 6; p++) begin
            int exp_n;
            exp_n = 39 / p;
            wr(A_CNT, 64'd0);
            wr(ca(1, 0), (64'd8 << 9) | 64'h4C);
            wr(ca(1, 8), 64'(p));
            wr(A_GCFG, 64'd1);
            watch(1, 40, n, first, last);
            chk("R6 sweep count", 64'(n), 64'(exp_n));
            chk("R6 sweep first", first, 64'(p + 1));
            chk("R6 sweep last", last, 64'(exp_n * p + 1));
            wr(A_GCFG, 64'd0);
        end

        // R9 level mode on channel 2, route 9
        wr(A_CNT, 64'd0);
        wr(ca(2, 0), (64'd9 << 9) | 64'h6);
        wr(ca(2, 8), 64'd5);
        chk("R10 ch2 route", 64'(route[14:10]), 64'd9);
        wr(A_GCFG, 64'd1);
        watch(2, 20, n, first, last);
        chk("R9 level high cycles", 64'(n), 64'd15);
        chk("R9 level first", first, 64'd6);
        wr(A_GCFG, 64'd0);
        rd(A_GSTS, v); chk("R9 status set", v, 64'd4);
        wr(A_GSTS, 64'd0);
        rd(A_GSTS, v); chk("R9 zero write no effect", v, 64'd4);
        wr(A_GSTS, 64'd3);
        rd(A_GSTS, v); chk("R9 other bits no effect", v, 64'd4);
        chk("R9 line still high", 64'(irq[2]), 64'd1);
        wr(A_GSTS, 64'd4);
        rd(A_GSTS, v); chk("R9 cleared", v, 64'd0);
        chk("R9 line low", 64'(irq[2]), 64'd0);

        // R11 disabled channel stays silent
        wr(A_CNT, 64'd0);
        wr(ca(0, 0), 64'd8 << 9);
        wr(ca(0, 8), 64'd5);
        wr(A_GCFG, 64'd1);
        watch(0, 20, n, first, last);
        chk("R11 disabled silent", 64'(n), 64'd0);
        wr(A_GCFG, 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule